// File: doc/BRIEF.md
# SCL Rate Generator

This block sets the pace of the serial clock for a two-wire (I2C) bus master. A nine-bit clock-control word packs two fields. The low three bits hold a pre-divider, and the generator makes an internal tick from it once every (pre-divider + 1) system clocks. The upper six bits hold an SCL divider. One SCL period lasts N internal ticks, where N is 20, plus eight times the SCL divider, plus a small delay-compensation count F. F covers the bus rise and fall times and the internal delay. Software works F out and presents it on a four-bit input.

The byte engine raises a request while it wants the bus clocked. The generator then drives SCL low for the first part of each period and releases it for the rest. It signals the start of each phase to the byte engine with one-cycle pulses. After releasing SCL it waits until the sampled line is really high before it counts the high phase. A slave that holds SCL low therefore stretches the period. The generator takes a new clock-control word and a new F only when a period begins. With no request it rests with SCL released.

Top module: `sclRateGen`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, sclDriveLow, lowStart and highStart are all 0.
- R2: While busReq is 0 and no period is running, SCL stays released (sclDriveLow = 0) and neither pulse occurs.
- R3: The low phase holds sclDriveLow at 1 for ceil(N/2) x (CDF + 1) system clocks, where N = 20 + 8 x SCGD + F.
- R4: With busReq held at 1, the high phase runs from the highStart pulse up to the next lowStart pulse and lasts floor(N/2) x (CDF + 1) system clocks.
- R5: After SCL is released, highStart appears in the second cycle after sclIn is seen high. With no stretching this is two cycles after the release. While sclIn is held low, highStart does not occur and SCL stays released.
- R6: clkCtrl and fComp are captured at the start of a period. A change made during a period first affects the next period.
- R7: When busReq falls, the running period completes and then the generator goes idle, with no further lowStart. A new period begins, with lowStart, on the first cycle after busReq rises again.
- R8: lowStart is a one-cycle pulse in the first cycle of sclDriveLow = 1. highStart is a one-cycle pulse in the first cycle of the high count, and sclDriveLow is 0 during it.
- R9: In clkCtrl, bits [2:0] are the pre-divider CDF and bits [8:3] are the SCL divider SCGD. The internal tick comes once every CDF + 1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Byte engine asks for SCL periods |
| clkCtrl | input | 9 | Clock-control word: SCL divider above pre-divider |
| fComp | input | 4 | Delay-compensation count F |
| sclIn | input | 1 | Level on the SCL line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| lowStart | output | 1 | Pulse at the start of the low phase |
| highStart | output | 1 | Pulse when the high count begins |

## Verification
The hardest case to reach is a slave that holds SCL low after the generator has released it. The port-level line model closes the loop by itself, so the stretch never appears on its own. The bench raises a stretch flag while the low phase is still running. It holds the flag for a fixed number of cycles after the release and then drops it. It then counts the cycles until highStart, which must be two. The other hard cases are a clock-control change landing mid-period and busReq falling mid-period. Both are timed from an observed lowStart pulse.

// File: rtl/sclRateGen_pkg.sv
package sclRateGen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_LOW       = 2'd1,
    ST_WAIT_HIGH = 2'd2,
    ST_HIGH      = 2'd3
  } sclPhase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic loadLow;   // capture config, load low count, restart prescaler
    logic loadHigh;  // load high count, restart prescaler
    logic run;       // prescaler and phase counter active
  } sclStrobe_t;

endpackage

// File: rtl/sclRateGenDp.sv
module sclRateGenDp
  import sclRateGen_pkg::*;
#(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int F_W        = 4,
  parameter int FIXED_CNT  = 20,
  parameter int SCGD_SHIFT = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CDF_W+SCGD_W-1:0] clkCtrl,
  input  logic [F_W-1:0]          fComp,
  input  sclStrobe_t              strobe,
  output logic                    tick,
  output logic                    cntLast
);

  localparam int MAX_PERIOD = FIXED_CNT + ((2**SCGD_W - 1) << SCGD_SHIFT) + (2**F_W - 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [CDF_W-1:0]  cdfIn;
  logic [SCGD_W-1:0] scgdIn;
  logic [CNT_W-1:0]  periodNew;
  logic [CNT_W:0]    periodUp;
  logic [CNT_W-1:0]  lowNew;
  logic [CNT_W-1:0]  highNew;

  logic [CDF_W-1:0]  cdfQ;
  logic [CNT_W-1:0]  highQ;
  logic [CNT_W-1:0]  cnt;
  logic [CDF_W-1:0]  preCnt;

  assign cdfIn  = clkCtrl[CDF_W-1:0];
  assign scgdIn = clkCtrl[CDF_W+SCGD_W-1:CDF_W];

  // period length from the presented configuration
  always_comb begin
    periodNew = CNT_W'(FIXED_CNT) + (CNT_W'(scgdIn) << SCGD_SHIFT) + CNT_W'(fComp);
    periodUp  = {1'b0, periodNew} + (CNT_W+1)'(1);
    lowNew    = periodUp[CNT_W:1];
    highNew   = periodNew - lowNew;
  end

  assign tick    = strobe.run && (preCnt == cdfQ);
  assign cntLast = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cdfQ   <= '0;
      highQ  <= '0;
      cnt    <= '0;
      preCnt <= '0;
    end else if (strobe.loadLow) begin
      cdfQ   <= cdfIn;
      highQ  <= highNew;
      cnt    <= lowNew;
      preCnt <= '0;
    end else if (strobe.loadHigh) begin
      cnt    <= highQ;
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
      cnt    <= cnt - CNT_W'(1);
    end else if (strobe.run) begin
      preCnt <= preCnt + CDF_W'(1);
    end
  end

  // prescaler never passes the captured pre-divider value
  assert_prescale_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= cdfQ);

  // phase counter is never empty while a phase is being timed
  assert_count_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (cnt != '0));

endmodule

// File: rtl/sclRateGenCtl.sv
module sclRateGenCtl
  import sclRateGen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReq,
  input  logic       sclIn,
  input  logic       tick,
  input  logic       cntLast,
  output sclStrobe_t strobe,
  output logic       sclDriveLow,
  output logic       lowStart,
  output logic       highStart
);

  sclPhase_e state;
  sclPhase_e stateNxt;
  logic      sclSampled;
  logic      lowStartQ;
  logic      highStartQ;
  logic      phaseDone;

  assign phaseDone = tick && cntLast;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    strobe.run = (state == ST_LOW) || (state == ST_HIGH);
    case (state)
      ST_IDLE: begin
        if (busReq) begin
          strobe.loadLow = 1'b1;
          stateNxt       = ST_LOW;
        end
      end
      ST_LOW: begin
        if (phaseDone) stateNxt = ST_WAIT_HIGH;
      end
      ST_WAIT_HIGH: begin
        if (sclSampled) begin
          strobe.loadHigh = 1'b1;
          stateNxt        = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (phaseDone) begin
          if (busReq) begin
            strobe.loadLow = 1'b1;
            stateNxt       = ST_LOW;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sclSampled <= 1'b0;
      lowStartQ  <= 1'b0;
      highStartQ <= 1'b0;
    end else begin
      state      <= stateNxt;
      sclSampled <= sclIn;
      lowStartQ  <= strobe.loadLow;
      highStartQ <= strobe.loadHigh;
    end
  end

  assign sclDriveLow = (state == ST_LOW);
  assign lowStart    = lowStartQ;
  assign highStart   = highStartQ;

  assert_low_start_align_R8: assert property (@(posedge clk) disable iff (!rstN)
    lowStart |-> sclDriveLow);

  assert_low_rise_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> lowStart);

  assert_high_released_R8: assert property (@(posedge clk) disable iff (!rstN)
    highStart |-> !sclDriveLow);

  assert_high_after_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    highStart |-> $past(sclIn, 2));

  assert_start_needs_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> $past(busReq));

endmodule

// File: rtl/sclRateGen.sv
module sclRateGen
  import sclRateGen_pkg::*;
#(
  parameter int CDF_W      = 3,
  parameter int SCGD_W     = 6,
  parameter int F_W        = 4,
  parameter int FIXED_CNT  = 20,
  parameter int SCGD_SHIFT = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busReq,
  input  logic [CDF_W+SCGD_W-1:0] clkCtrl,
  input  logic [F_W-1:0]          fComp,
  input  logic                    sclIn,
  output logic                    sclDriveLow,
  output logic                    lowStart,
  output logic                    highStart
);

  sclStrobe_t strobe;
  logic       tick;
  logic       cntLast;

  sclRateGenCtl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .busReq      (busReq),
    .sclIn       (sclIn),
    .tick        (tick),
    .cntLast     (cntLast),
    .strobe      (strobe),
    .sclDriveLow (sclDriveLow),
    .lowStart    (lowStart),
    .highStart   (highStart)
  );

  sclRateGenDp #(
    .CDF_W      (CDF_W),
    .SCGD_W     (SCGD_W),
    .F_W        (F_W),
    .FIXED_CNT  (FIXED_CNT),
    .SCGD_SHIFT (SCGD_SHIFT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .clkCtrl (clkCtrl),
    .fComp   (fComp),
    .strobe  (strobe),
    .tick    (tick),
    .cntLast (cntLast)
  );

endmodule

// File: tb/sclRateGen_bench.sv
module sclRateGen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReq = 1'b0;
  logic [8:0] clkCtrl = '0;
  logic [3:0] fComp = '0;
  logic       stretch = 1'b0;
  logic       sclIn;
  logic       sclDriveLow;
  logic       lowStart;
  logic       highStart;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  // open-drain line: low if the generator or a stretching slave pulls it
  assign sclIn = ~sclDriveLow & ~stretch;

  sclRateGen u_sclRateGen (
    .clk         (clk),
    .rstN        (rstN),
    .busReq      (busReq),
    .clkCtrl     (clkCtrl),
    .fComp       (fComp),
    .sclIn       (sclIn),
    .sclDriveLow (sclDriveLow),
    .lowStart    (lowStart),
    .highStart   (highStart)
  );

  // {scgd, cdf, f, expected low clocks, expected high clocks}
  localparam int VEC [8][5] = '{
    '{ 0, 0,  0,   10,   10},
    '{ 0, 0,  5,   13,   12},
    '{ 1, 1,  3,   32,   30},
    '{ 3, 7,  7,  208,  200},
    '{63, 0, 15,  270,  269},
    '{10, 2,  0,  150,  150},
    '{ 5, 4,  9,  175,  170},
    '{63, 7, 15, 2160, 2152}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input int scgd, input int cdf, input int f);
    clkCtrl = 9'((scgd << 3) | cdf);
    fComp   = 4'(f);
  endtask

  task automatic waitLowStart();
    do @(negedge clk); while (!lowStart);
  endtask

  // measures one period starting at the next lowStart; optional config change there
  task automatic measure(input bit doChange, input int scgd, input int cdf, input int f,
                         output int lowLen, output int gapLen, output int highLen);
    waitLowStart();
    if (doChange) setCfg(scgd, cdf, f);
    lowLen = 0;
    while (sclDriveLow) begin lowLen++; @(negedge clk); end
    gapLen = 0;
    while (!highStart) begin gapLen++; @(negedge clk); end
    highLen = 0;
    while (!lowStart) begin highLen++; @(negedge clk); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    int lowLen, gapLen, highLen, cnt;
    bit seen;

    // R1: reset state
    repeat (4) @(negedge clk);
    check(!sclDriveLow && !lowStart && !highStart, "R1 reset outputs", int'(sclDriveLow), 0);
    rstN = 1'b1;

    // R2: idle without request
    seen = 1'b0;
    repeat (100) begin
      @(negedge clk);
      if (sclDriveLow || lowStart || highStart) seen = 1'b1;
    end
    check(!seen, "R1 R2 idle released, no pulses", int'(seen), 0);

    // R3 R4 R9: table walk; first period after a change is discarded
    setCfg(VEC[0][0], VEC[0][1], VEC[0][2]);
    busReq = 1'b1;
    for (int i = 0; i < 8; i++) begin
      setCfg(VEC[i][0], VEC[i][1], VEC[i][2]);
      measure(1'b0, 0, 0, 0, lowLen, gapLen, highLen);
      measure(1'b0, 0, 0, 0, lowLen, gapLen, highLen);
      check(lowLen == VEC[i][3], $sformatf("R3 R9 low phase vec %0d", i), lowLen, VEC[i][3]);
      check(gapLen == 2, $sformatf("R5 release gap vec %0d", i), gapLen, 2);
      check(highLen == VEC[i][4], $sformatf("R4 R9 high phase vec %0d", i), highLen, VEC[i][4]);
    end

    // R8: pulse shapes
    setCfg(0, 0, 0);
    measure(1'b0, 0, 0, 0, lowLen, gapLen, highLen);
    check(lowStart && sclDriveLow, "R8 lowStart with drive low", int'(sclDriveLow), 1);
    @(negedge clk);
    check(!lowStart, "R8 lowStart one cycle", int'(lowStart), 0);
    while (!highStart) @(negedge clk);
    check(!sclDriveLow, "R8 highStart while released", int'(sclDriveLow), 0);
    @(negedge clk);
    check(!highStart, "R8 highStart one cycle", int'(highStart), 0);

    // R5: slave stretches SCL for 37 cycles after release
    waitLowStart();
    stretch = 1'b1;
    while (sclDriveLow) @(negedge clk);
    seen = 1'b0;
    repeat (37) begin
      if (highStart || sclDriveLow) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R5 no high count while stretched", int'(seen), 0);
    stretch = 1'b0;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!highStart && cnt < 50);
    check(cnt == 2, "R5 high count after stretch release", cnt, 2);

    // R6: change mid-period applies next period
    measure(1'b1, 2, 1, 0, lowLen, gapLen, highLen);
    check(lowLen == 10, "R6 current low unchanged", lowLen, 10);
    check(highLen == 10, "R6 current high unchanged", highLen, 10);
    measure(1'b0, 0, 0, 0, lowLen, gapLen, highLen);
    check(lowLen == 36, "R6 next low uses new config", lowLen, 36);
    check(highLen == 36, "R6 next high uses new config", highLen, 36);

    // R7: request drops during low phase
    setCfg(0, 0, 0);
    measure(1'b0, 0, 0, 0, lowLen, gapLen, highLen);
    measure(1'b0, 0, 0, 0, lowLen, gapLen, highLen);
    @(negedge clk);
    busReq = 1'b0;
    lowLen = 1;
    while (sclDriveLow) begin lowLen++; @(negedge clk); end
    check(lowLen == 10, "R7 low phase completes after drop", lowLen, 10);
    cnt = 0;
    while (!highStart && cnt < 50) begin cnt++; @(negedge clk); end
    check(highStart, "R7 high phase still starts", int'(highStart), 1);
    seen = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (lowStart || sclDriveLow) seen = 1'b1;
    end
    check(!seen, "R7 R2 idle after final period", int'(seen), 0);
    busReq = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!lowStart && cnt < 50);
    check(cnt == 1, "R7 restart one cycle after request", cnt, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule